// File: doc/BRIEF.md
# Flash Password Security Gate

This block sits in front of a small on-chip flash array and decides whether masters that are not trusted may use it. A 64-bit password lives in four protected flash words at word addresses 0x40 to 0x43, with the most significant word at 0x40. After every reset a loader walks those four words and latches the password. Until that walk finishes, the block answers no flash request.

Software unlocks the array by writing a 64-bit key as four 16-bit words through a small register bus. Register 0 takes the most significant key word and register 3 the least significant. The key is compared with the latched password only once all four key registers hold fresh words. A key that does not match leaves the block locked. A password made only of zero bits or only of one bits cannot protect anything, so in either case the block counts as unlocked and ignores the key.

Trusted masters mark their requests as secure and may always use the array. Other masters are let through only while the block is unlocked. Software can lock the block again at any time through a control register.

Top module: `flash_guard_top`

## Requirements
- R1: After reset is released, `fl_ready` rises on the fourth rising clock edge. Until then `unlocked` is 0 and a flash request gets no `fl_done`.
- R2: When key registers 0..3 hold, in that order, the password words from flash 0x40..0x43, the block unlocks on the edge that stores the last of the four writes. The four writes may come in any order.
- R3: The compare is armed only once all four key registers have been written since the last compare, relock or flash read at 0x40..0x43. A flash read of any of those addresses discards key words written before it. A partial sequence leaves the block locked.
- R4: A complete key that differs from the password leaves `unlocked` at 0, and a later erase or clear from a non-secure master fails with `fl_err`.
- R5: If the latched password is all 0x0000 words or all 0xFFFF words, `unlocked` is 1 as soon as `fl_ready` is 1, whatever key is written. A relock write has no effect in that case.
- R6: While locked, a non-secure read (op 0) completes with `fl_done`=1, `fl_err`=0 and `fl_rdata`=0x0000.
- R7: While locked, a non-secure program (op 1), erase (op 2) or clear (op 3) leaves the array unchanged and completes with `fl_done`=1 and `fl_err`=1.
- R8: A request with `fl_secure`=1 is always carried out and never flags `fl_err`.
- R9: Every accepted request answers one cycle later with `fl_done`. A read returns the addressed word. A program ANDs `fl_wdata` into the word. An erase sets every word to 0xFFFF. A clear sets every word to 0x0000. A write-type request returns `fl_rdata`=0.
- R10: Register 4 reads bit 0 = unlocked and bit 1 = ready, all other bits 0. Key registers 0..3 read back as 0. Writing register 4 with bit 0 set locks the block and discards pending key words.
- R11: Reset locks the block unless R5 applies. Flash contents survive reset, and the password is latched again from the current contents of 0x40..0x43.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index: 0..3 key words, 4 control/status |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| fl_req | input | 1 | Flash request valid |
| fl_op | input | 2 | 0 read, 1 program, 2 erase, 3 clear |
| fl_secure | input | 1 | Request comes from a trusted master |
| fl_addr | input | 8 | Flash word address |
| fl_wdata | input | 16 | Program data |
| fl_done | output | 1 | Response valid, one cycle after request |
| fl_err | output | 1 | Request was dropped by the lock |
| fl_rdata | output | 16 | Read data |
| fl_ready | output | 1 | Password has been latched |
| unlocked | output | 1 | Non-secure access is allowed |

## Verification
The properties assume that a master issues at most one flash request and at most one register write per cycle. They also assume that requests hold only defined operation codes. The bench drives every stimulus from tasks that raise a strobe for exactly one cycle and wait for the response before starting the next. It never overlaps a flash read of the password window with a key write in the same cycle, so whether a key word is kept or discarded always has one defined answer.

// File: rtl/fg_pkg.sv
package fg_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_CLEAR = 2'd3
    } fl_op_e;

    localparam int KEY_WORDS = 4;
    localparam int CTRL_REG  = 4;
endpackage

// File: rtl/fg_flash_array.sv
module fg_flash_array
    import fg_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int NWORDS    = 4,
    parameter int PWD_BASE  = 64,
    parameter logic [NWORDS*DATA_W-1:0] INIT_PWD = '0
) (
    input  logic              clk,
    input  logic              we,
    input  fl_op_e            op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic [DATA_W-1:0] ld_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Non-volatile contents: set once at power-up, untouched by rst_n.
    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '1;
        for (int w = 0; w < NWORDS; w++)
            mem[PWD_BASE + w] = INIT_PWD[(NWORDS-1-w)*DATA_W +: DATA_W];
    end

    always @(posedge clk) begin
        if (we) begin
            case (op)
                OP_PROG:  mem[addr] <= mem[addr] & wdata;
                OP_ERASE: for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
                OP_CLEAR: for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
                default:  ;
            endcase
        end
    end

    assign rd_data = mem[addr];
    assign ld_data = mem[ld_addr];
endmodule

// File: rtl/fg_pwd_loader.sv
module fg_pwd_loader #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int NWORDS   = 4,
    parameter int PWD_BASE = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DATA_W-1:0]        ld_data,
    output logic [ADDR_W-1:0]        ld_addr,
    output logic [NWORDS*DATA_W-1:0] pwd,
    output logic                     ready
);
    localparam int IW = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam int PW = NWORDS * DATA_W;

    typedef struct packed {
        logic [IW-1:0] idx;
        logic          ready;
        logic [PW-1:0] pwd;
    } ld_state_t;

    ld_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.ready) begin
            for (int w = 0; w < NWORDS; w++)
                if (int'(st_q.idx) == w)
                    st_d.pwd[(NWORDS-1-w)*DATA_W +: DATA_W] = ld_data;
            if (st_q.idx == IW'(NWORDS - 1)) st_d.ready = 1'b1;
            else                             st_d.idx   = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ld_addr = ADDR_W'(PWD_BASE) + ADDR_W'(st_q.idx);
    assign pwd     = st_q.pwd;
    assign ready   = st_q.ready;
endmodule

// File: rtl/fg_key_unit.sv
module fg_key_unit
    import fg_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NWORDS = 4,
    parameter int RA_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ready,
    input  logic [NWORDS*DATA_W-1:0] pwd,
    input  logic                     pwd_rd,
    input  logic                     reg_wr,
    input  logic [RA_W-1:0]          reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    output logic                     dontcare,
    output logic                     unlocked
);
    localparam int PW = NWORDS * DATA_W;

    typedef struct packed {
        logic [PW-1:0]     key;
        logic [NWORDS-1:0] fresh;
        logic              open;
    } key_state_t;

    key_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pwd_rd) st_d.fresh = '0;
        if (reg_wr && ready) begin
            if (int'(reg_addr) < NWORDS) begin
                for (int i = 0; i < NWORDS; i++) begin
                    if (int'(reg_addr) == i) begin
                        st_d.key[(NWORDS-1-i)*DATA_W +: DATA_W] = reg_wdata;
                        st_d.fresh[i] = 1'b1;
                    end
                end
                if (&st_d.fresh) begin
                    if (st_d.key == pwd) st_d.open = 1'b1;
                    st_d.fresh = '0;
                end
            end else if (int'(reg_addr) == CTRL_REG && reg_wdata[0]) begin
                st_d.open  = 1'b0;
                st_d.fresh = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dontcare = (pwd == '0) || (pwd == '1);
    assign unlocked = ready && (dontcare || st_q.open);

    always_comb begin
        reg_rdata = '0;
        if (int'(reg_addr) == CTRL_REG) begin
            reg_rdata[0] = unlocked;
            reg_rdata[1] = ready;
        end
    end
endmodule

// File: rtl/fg_access_gate.sv
module fg_access_gate
    import fg_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int NWORDS   = 4,
    parameter int PWD_BASE = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  fl_op_e            op,
    input  logic              secure,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ready,
    input  logic              unlocked,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic              arr_we,
    output logic              pwd_rd,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(PWD_BASE);
    localparam logic [ADDR_W:0] WIN_HI = (ADDR_W+1)'(PWD_BASE + NWORDS);

    typedef struct packed {
        logic              done;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    rsp_t rsp_d, rsp_q;
    logic accept, permit, is_read, in_win;

    always_comb begin
        accept  = req && ready;
        permit  = secure || unlocked;
        is_read = (op == OP_READ);
        in_win  = ({1'b0, addr} >= WIN_LO) && ({1'b0, addr} < WIN_HI);
        arr_we  = accept && permit && !is_read;
        pwd_rd  = accept && is_read && in_win;

        rsp_d.done  = accept;
        rsp_d.err   = accept && !permit && !is_read;
        rsp_d.rdata = (accept && permit && is_read) ? arr_rdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign done  = rsp_q.done;
    assign err   = rsp_q.err;
    assign rdata = rsp_q.rdata;
endmodule

// File: rtl/flash_guard_top.sv
module flash_guard_top
    import fg_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int REG_AW   = 3,
    parameter int PWD_BASE = 64,
    parameter logic [KEY_WORDS*DATA_W-1:0] INIT_PWD = 64'h1234_5678_9ABC_DEF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              fl_req,
    input  logic [1:0]        fl_op,
    input  logic              fl_secure,
    input  logic [ADDR_W-1:0] fl_addr,
    input  logic [DATA_W-1:0] fl_wdata,
    output logic              fl_done,
    output logic              fl_err,
    output logic [DATA_W-1:0] fl_rdata,
    output logic              fl_ready,
    output logic              unlocked
);
    localparam int PW = KEY_WORDS * DATA_W;

    fl_op_e            op_w;
    logic              arr_we, pwd_rd, dontcare;
    logic [DATA_W-1:0] arr_rdata, ld_data;
    logic [ADDR_W-1:0] ld_addr;
    logic [PW-1:0]     pwd;

    assign op_w = fl_op_e'(fl_op);

    fg_flash_array #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NWORDS(KEY_WORDS),
        .PWD_BASE(PWD_BASE), .INIT_PWD(INIT_PWD)
    ) u_array (
        .clk(clk), .we(arr_we), .op(op_w), .addr(fl_addr), .wdata(fl_wdata),
        .rd_data(arr_rdata), .ld_addr(ld_addr), .ld_data(ld_data)
    );

    fg_pwd_loader #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NWORDS(KEY_WORDS), .PWD_BASE(PWD_BASE)
    ) u_loader (
        .clk(clk), .rst_n(rst_n), .ld_data(ld_data), .ld_addr(ld_addr),
        .pwd(pwd), .ready(fl_ready)
    );

    fg_key_unit #(
        .DATA_W(DATA_W), .NWORDS(KEY_WORDS), .RA_W(REG_AW)
    ) u_key (
        .clk(clk), .rst_n(rst_n), .ready(fl_ready), .pwd(pwd), .pwd_rd(pwd_rd),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dontcare(dontcare), .unlocked(unlocked)
    );

    fg_access_gate #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NWORDS(KEY_WORDS), .PWD_BASE(PWD_BASE)
    ) u_gate (
        .clk(clk), .rst_n(rst_n), .req(fl_req), .op(op_w), .secure(fl_secure),
        .addr(fl_addr), .ready(fl_ready), .unlocked(unlocked),
        .arr_rdata(arr_rdata), .arr_we(arr_we), .pwd_rd(pwd_rd),
        .done(fl_done), .err(fl_err), .rdata(fl_rdata)
    );
endmodule

// File: rtl/fg_checker.sv
module fg_checker #(
    parameter int DATA_W = 16,
    parameter int RA_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [RA_W-1:0]   reg_addr,
    input logic              relock_bit,
    input logic              fl_req,
    input logic [1:0]        fl_op,
    input logic              fl_secure,
    input logic              fl_done,
    input logic              fl_err,
    input logic [DATA_W-1:0] fl_rdata,
    input logic              fl_ready,
    input logic              unlocked,
    input logic              dontcare
);
    // R9
    err_has_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_err |-> fl_done);

    // R1
    done_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_done |-> $past(fl_req && fl_ready));

    // R1
    open_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked |-> fl_ready);

    // R7
    drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_err |-> $past(!fl_secure && !unlocked && fl_op != 2'd0));

    // R6
    locked_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fl_req && fl_ready && fl_op == 2'd0 && !fl_secure && !unlocked)
        |-> fl_rdata == '0);

    // R8
    secure_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fl_req && fl_secure) |-> !fl_err);

    // R10
    relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_wr && int'(reg_addr) == 4 && relock_bit && !dontcare)
        |-> !unlocked);

    // R2
    unlock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> ($past(reg_wr) || $rose(fl_ready)));
endmodule

bind flash_guard_top fg_checker #(.DATA_W(DATA_W), .RA_W(REG_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .relock_bit(reg_wdata[0]), .fl_req(fl_req), .fl_op(fl_op),
    .fl_secure(fl_secure), .fl_done(fl_done), .fl_err(fl_err),
    .fl_rdata(fl_rdata), .fl_ready(fl_ready), .unlocked(unlocked),
    .dontcare(dontcare)
);

// File: tb/sim_flash_guard_top.sv
module sim_flash_guard_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        fl_req = 1'b0;
    logic [1:0]  fl_op = '0;
    logic        fl_secure = 1'b0;
    logic [7:0]  fl_addr = '0;
    logic [15:0] fl_wdata = '0;
    logic        fl_done, fl_err, fl_ready, unlocked;
    logic [15:0] fl_rdata;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    flash_guard_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fl_req(fl_req),
        .fl_op(fl_op), .fl_secure(fl_secure), .fl_addr(fl_addr),
        .fl_wdata(fl_wdata), .fl_done(fl_done), .fl_err(fl_err),
        .fl_rdata(fl_rdata), .fl_ready(fl_ready), .unlocked(unlocked)
    );

    // {op[1:0], secure, addr[7:0], wdata[15:0], exp_err, exp_rdata[15:0]}
    // Walked in the locked state right after the first reset.
    localparam int NV = 11;
    localparam logic [43:0] VEC [NV] = '{
        {2'd0, 1'b0, 8'h10, 16'h0000, 1'b0, 16'h0000},  // R6
        {2'd0, 1'b1, 8'h10, 16'h0000, 1'b0, 16'hFFFF},  // R8
        {2'd1, 1'b0, 8'h10, 16'h00FF, 1'b1, 16'h0000},  // R7
        {2'd0, 1'b1, 8'h10, 16'h0000, 1'b0, 16'hFFFF},  // R7 unchanged
        {2'd1, 1'b1, 8'h10, 16'h00FF, 1'b0, 16'h0000},  // R8
        {2'd0, 1'b1, 8'h10, 16'h0000, 1'b0, 16'h00FF},  // R9
        {2'd0, 1'b1, 8'h41, 16'h0000, 1'b0, 16'h5678},  // R8
        {2'd2, 1'b0, 8'h00, 16'h0000, 1'b1, 16'h0000},  // R7
        {2'd0, 1'b1, 8'h10, 16'h0000, 1'b0, 16'h00FF},  // R7 unchanged
        {2'd3, 1'b0, 8'h00, 16'h0000, 1'b1, 16'h0000},  // R7
        {2'd0, 1'b1, 8'h43, 16'h0000, 1'b0, 16'hDEF0}   // R7 unchanged
    };

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic acc(input logic [1:0] op, input logic sec, input logic [7:0] a,
                       input logic [15:0] wd, output logic d, output logic e,
                       output logic [15:0] r);
        @(negedge clk);
        fl_req = 1'b1; fl_op = op; fl_secure = sec; fl_addr = a; fl_wdata = wd;
        @(negedge clk);
        d = fl_done; e = fl_err; r = fl_rdata;
        fl_req = 1'b0;
    endtask

    task automatic wreg(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic do_reset;
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic write_key(input logic [63:0] k);
        for (int i = 0; i < 4; i++) wreg(3'(i), k[(3-i)*16 +: 16]);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 50000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=<50000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic d, e;
        logic [15:0] r, v;

        // R1: reset state and the load window
        repeat (2) @(negedge clk);
        check(!unlocked && !fl_ready, "R1 reset", {unlocked, fl_ready}, 0);
        rst_n = 1'b1;
        fl_req = 1'b1; fl_op = 2'd0; fl_secure = 1'b1; fl_addr = 8'h10;
        repeat (3) @(negedge clk);
        check(!fl_ready && !fl_done, "R1 loading", {fl_ready, fl_done}, 0);
        fl_req = 1'b0;
        @(negedge clk);
        check(fl_ready && !unlocked, "R1 ready on 4th edge", {fl_ready, unlocked}, 2);
        repeat (2) @(negedge clk);

        // Vector table, locked state
        for (int i = 0; i < NV; i++) begin
            acc(VEC[i][43:42], VEC[i][41], VEC[i][40:33], VEC[i][32:17], d, e, r);
            check(d && e == VEC[i][16] && r == VEC[i][15:0], "R6/R7/R8 vector",
                  {i[7:0], 3'b0, d, 3'b0, e, r}, {i[7:0], 4'h1, 3'b0, VEC[i][16], VEC[i][15:0]});
        end

        // R4: wrong key
        write_key(64'h1234_5678_9ABC_DEF1);
        check(!unlocked, "R4 wrong key", unlocked, 0);
        acc(2'd2, 1'b0, 8'h00, 16'h0, d, e, r);
        check(d && e, "R4 erase fails", {d, e}, 3);

        // R3: partial sequence, then read of the window discards words
        wreg(3'd0, 16'h1234); wreg(3'd1, 16'h5678); wreg(3'd2, 16'h9ABC);
        check(!unlocked, "R3 partial", unlocked, 0);
        acc(2'd0, 1'b0, 8'h40, 16'h0, d, e, r);
        wreg(3'd3, 16'hDEF0);
        check(!unlocked, "R3 read discards", unlocked, 0);

        // R2: correct key, written out of order
        wreg(3'd3, 16'hDEF0); wreg(3'd1, 16'h5678); wreg(3'd0, 16'h1234);
        check(!unlocked, "R2 before last word", unlocked, 0);
        wreg(3'd2, 16'h9ABC);
        check(unlocked, "R2 unlock", unlocked, 1);

        // R9: unlocked non-secure access
        acc(2'd0, 1'b0, 8'h41, 16'h0, d, e, r);
        check(d && !e && r == 16'h5678, "R9 read", r, 16'h5678);
        acc(2'd1, 1'b0, 8'h20, 16'h0F0F, d, e, r);
        check(d && !e && r == 16'h0, "R9 program rsp", {d, e, r}, 18'h20000);
        acc(2'd1, 1'b0, 8'h20, 16'hF0FF, d, e, r);
        acc(2'd0, 1'b0, 8'h20, 16'h0, d, e, r);
        check(r == 16'h000F, "R9 program AND", r, 16'h000F);

        // R10: register view and relock
        rreg(3'd4, v);
        check(v == 16'h0003, "R10 status open", v, 16'h0003);
        rreg(3'd1, v);
        check(v == 16'h0000, "R10 key reads zero", v, 0);
        wreg(3'd4, 16'h0001);
        rreg(3'd4, v);
        check(v == 16'h0002 && !unlocked, "R10 relock", v, 16'h0002);

        // R11: reset locks, contents survive
        write_key(64'h1234_5678_9ABC_DEF0);
        check(unlocked, "R2 unlock again", unlocked, 1);
        do_reset();
        check(fl_ready && !unlocked, "R11 reset locks", {fl_ready, unlocked}, 2);
        acc(2'd0, 1'b1, 8'h20, 16'h0, d, e, r);
        check(r == 16'h000F, "R11 contents kept", r, 16'h000F);

        // R9 erase, then R5/R11 all-ones password after reset
        write_key(64'h1234_5678_9ABC_DEF0);
        acc(2'd2, 1'b0, 8'h00, 16'h0, d, e, r);
        check(d && !e, "R9 erase accepted", {d, e}, 2);
        acc(2'd0, 1'b0, 8'h40, 16'h0, d, e, r);
        check(r == 16'hFFFF, "R9 erase", r, 16'hFFFF);
        do_reset();
        check(unlocked, "R5 all ones open", unlocked, 1);
        wreg(3'd4, 16'h0001);
        check(unlocked, "R5 relock ignored", unlocked, 1);
        write_key(64'h0000_0000_0000_0001);
        check(unlocked, "R5 key ignored", unlocked, 1);

        // R9 clear, then R5 all-zero password
        acc(2'd3, 1'b0, 8'h00, 16'h0, d, e, r);
        acc(2'd0, 1'b0, 8'h42, 16'h0, d, e, r);
        check(r == 16'h0000 && !e, "R9 clear", r, 0);
        do_reset();
        check(unlocked, "R5 all zeros open", unlocked, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule